// File: doc/BRIEF.md
# Per-Context Resource Allocation Unit

This block owns a pool of identical, spatially shared resources (execution units, cache ways and the like) and hands them out to a small set of security contexts. A context switch controller sends it allocate requests, which carry a context ID and a resource count, and release requests, which carry only a context ID. Each resource keeps its owner tag and a port number that is local to the owning context. These are brought out on flat vectors so that the datapath can steer traffic to the right unit.

Allocation is static and all-or-nothing. A context that asks for N resources gets exactly N of them, taken lowest free index first. If that cannot be done, it gets none and the controller sees a failure. A release first drives a flush window over the resources the context owns, and only then frees them. No other context can take a resource until it has been flushed.

Requests enter on a valid/ready handshake. `req_ready` is low only while a flush window runs, and a request is taken on any edge where both signals are high. The inputs must stay stable while `req_valid` is high and `req_ready` is low. Each accepted request yields exactly one single-cycle `rsp_valid` pulse with the verdict on `rsp_ok`. The response side has no back-pressure.

Top module: `rsa_alloc_unit`

## Requirements
- R1: After reset all resources are free, with owner 0 and port 0. `req_ready` is 1, while `rsp_valid` and `flush_active` are 0.
- R2: An allocate of count N (`req_release`=0) from a context that holds nothing succeeds when at least N resources are free. The N lowest-index free resources become busy with owner `req_ctx`, and `rsp_valid`=1, `rsp_ok`=1 appear in the cycle after acceptance.
- R3: The resources granted to a context get local ports 0, 1, … N-1 in ascending resource index. Resource i reports its owner in `res_owner[i*CTX_W +: CTX_W]` and its port in `res_port[i*PORT_W +: PORT_W]`.
- R4: An allocate asking for more resources than are free grants nothing, answers `rsp_ok`=0, and leaves every busy flag, owner and port unchanged.
- R5: An allocate with count 0, or from a context that already holds resources, fails (`rsp_ok`=0) and changes nothing.
- R6: A release (`req_release`=1) of a context that holds resources raises `flush_active` for exactly FLUSH_CYCLES cycles, starting the cycle after acceptance. During that window `flush_mask` equals the context's resources and `req_ready` is 0. In the next cycle those resources are free and `rsp_ok`=1.
- R7: A release of a context that holds nothing answers `rsp_ok`=1 in the cycle after acceptance, with no flush window.
- R8: Busy flags, owners and ports of resources change only in a cycle where `rsp_valid` is 1. Resources of other contexts are never affected by a request.
- R9: Every `rsp_valid` pulse answers exactly one accepted request, in order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request can be taken this cycle |
| req_release | input | 1 | 1 = release, 0 = allocate |
| req_ctx | input | CTX_W | Context ID of the request |
| req_cnt | input | CNT_W | Number of resources to allocate |
| rsp_valid | output | 1 | One-cycle response pulse |
| rsp_ok | output | 1 | 1 = request granted |
| res_busy | output | NUM_RES | Per-resource allocated flag |
| res_owner | output | NUM_RES*CTX_W | Per-resource owner tag |
| res_port | output | NUM_RES*PORT_W | Per-resource local port number |
| flush_active | output | 1 | Flush window in progress |
| flush_mask | output | NUM_RES | Resources being flushed |

## Verification
A corrupted owner tag or port register shows on `res_owner`/`res_port` from the cycle it happens, and the bench compares them at every response. A stale busy flag is exposed later: the next allocate either picks the wrong lowest-index slots or returns a wrong verdict. A flush counter that is off by one shows up as a flush window of the wrong length and a response pulse that comes early or late.

// File: rtl/rsa_pkg.sv
package rsa_pkg;
  typedef enum logic {ST_IDLE, ST_FLUSH} rsa_state_e;
endpackage

// File: rtl/rsa_free_rank.sv
module rsa_free_rank #(
  parameter int N      = 8,
  parameter int CNT_W  = 4,
  parameter int PORT_W = 3
) (
  input  logic [N-1:0]        free_i,
  input  logic [CNT_W-1:0]    cnt_i,
  output logic [N-1:0]        grant_o,
  output logic [N*PORT_W-1:0] rank_o,
  output logic                enough_o
);
  logic [CNT_W-1:0] acc;

  always_comb begin
    acc     = '0;
    grant_o = '0;
    rank_o  = '0;
    for (int i = 0; i < N; i++) begin
      rank_o[i*PORT_W +: PORT_W] = acc[PORT_W-1:0];
      grant_o[i] = free_i[i] && (acc < cnt_i);
      acc = acc + CNT_W'(free_i[i]);
    end
    enough_o = (cnt_i != '0) && (acc >= cnt_i);
  end
endmodule

// File: rtl/rsa_owner_match.sv
module rsa_owner_match #(
  parameter int N     = 8,
  parameter int CTX_W = 2
) (
  input  logic [N-1:0]       busy_i,
  input  logic [N*CTX_W-1:0] owner_i,
  input  logic [CTX_W-1:0]   ctx_i,
  output logic [N-1:0]       match_o
);
  for (genvar i = 0; i < N; i++) begin : g_cmp
    assign match_o[i] = busy_i[i] && (owner_i[i*CTX_W +: CTX_W] == ctx_i);
  end
endmodule

// File: rtl/rsa_slot.sv
module rsa_slot #(
  parameter int CTX_W  = 2,
  parameter int PORT_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              set_i,
  input  logic              clr_i,
  input  logic [CTX_W-1:0]  owner_i,
  input  logic [PORT_W-1:0] port_i,
  output logic              busy_o,
  output logic [CTX_W-1:0]  owner_o,
  output logic [PORT_W-1:0] port_o
);
  always_ff @(posedge clk) begin
    if (!rst_n || clr_i) begin
      busy_o  <= 1'b0;
      owner_o <= '0;
      port_o  <= '0;
    end else if (set_i) begin
      busy_o  <= 1'b1;
      owner_o <= owner_i;
      port_o  <= port_i;
    end
  end
endmodule

// File: rtl/rsa_alloc_unit.sv
module rsa_alloc_unit #(
  parameter int NUM_RES      = 8,
  parameter int NUM_CTX      = 4,
  parameter int FLUSH_CYCLES = 3,
  localparam int CTX_W  = (NUM_CTX > 1) ? $clog2(NUM_CTX) : 1,
  localparam int PORT_W = (NUM_RES > 1) ? $clog2(NUM_RES) : 1,
  localparam int CNT_W  = $clog2(NUM_RES + 1)
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      req_valid,
  output logic                      req_ready,
  input  logic                      req_release,
  input  logic [CTX_W-1:0]          req_ctx,
  input  logic [CNT_W-1:0]          req_cnt,
  output logic                      rsp_valid,
  output logic                      rsp_ok,
  output logic [NUM_RES-1:0]        res_busy,
  output logic [NUM_RES*CTX_W-1:0]  res_owner,
  output logic [NUM_RES*PORT_W-1:0] res_port,
  output logic                      flush_active,
  output logic [NUM_RES-1:0]        flush_mask
);
  import rsa_pkg::*;

  localparam int FC_W = $clog2(FLUSH_CYCLES + 1);

  rsa_state_e           state;
  logic [FC_W-1:0]      fcnt;
  logic [NUM_RES-1:0]   mask_q;
  logic [NUM_RES-1:0]   owned, grant, set_v, clr_v;
  logic [NUM_RES*PORT_W-1:0] rank;
  logic                 enough, held, alloc_ok, accept, flush_done;

  assign req_ready  = (state == ST_IDLE);
  assign accept     = req_valid && req_ready;
  assign held       = |owned;
  assign alloc_ok   = !held && enough;
  assign flush_done = (state == ST_FLUSH) && (fcnt == '0);

  assign set_v = (accept && !req_release && alloc_ok) ? grant : '0;
  assign clr_v = flush_done ? mask_q : '0;

  assign flush_active = (state == ST_FLUSH);
  assign flush_mask   = mask_q;

  rsa_owner_match #(.N(NUM_RES), .CTX_W(CTX_W)) u_match (
    .busy_i(res_busy), .owner_i(res_owner), .ctx_i(req_ctx), .match_o(owned)
  );

  rsa_free_rank #(.N(NUM_RES), .CNT_W(CNT_W), .PORT_W(PORT_W)) u_rank (
    .free_i(~res_busy), .cnt_i(req_cnt), .grant_o(grant), .rank_o(rank),
    .enough_o(enough)
  );

  for (genvar i = 0; i < NUM_RES; i++) begin : g_slot
    rsa_slot #(.CTX_W(CTX_W), .PORT_W(PORT_W)) u_slot (
      .clk    (clk),
      .rst_n  (rst_n),
      .set_i  (set_v[i]),
      .clr_i  (clr_v[i]),
      .owner_i(req_ctx),
      .port_i (rank[i*PORT_W +: PORT_W]),
      .busy_o (res_busy[i]),
      .owner_o(res_owner[i*CTX_W +: CTX_W]),
      .port_o (res_port[i*PORT_W +: PORT_W])
    );
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state     <= ST_IDLE;
      fcnt      <= '0;
      mask_q    <= '0;
      rsp_valid <= 1'b0;
      rsp_ok    <= 1'b0;
    end else begin
      rsp_valid <= 1'b0;
      if (accept) begin
        if (req_release) begin
          if (held) begin
            state  <= ST_FLUSH;
            fcnt   <= FC_W'(FLUSH_CYCLES - 1);
            mask_q <= owned;
          end else begin
            rsp_valid <= 1'b1;
            rsp_ok    <= 1'b1;
          end
        end else begin
          rsp_valid <= 1'b1;
          rsp_ok    <= alloc_ok;
        end
      end else if (state == ST_FLUSH) begin
        if (flush_done) begin
          state     <= ST_IDLE;
          mask_q    <= '0;
          rsp_valid <= 1'b1;
          rsp_ok    <= 1'b1;
        end else begin
          fcnt <= fcnt - 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/rsa_alloc_unit_chk.sv
module rsa_alloc_unit_chk #(
  parameter int NUM_RES      = 8,
  parameter int NUM_CTX      = 4,
  parameter int FLUSH_CYCLES = 3,
  localparam int CTX_W  = (NUM_CTX > 1) ? $clog2(NUM_CTX) : 1,
  localparam int PORT_W = (NUM_RES > 1) ? $clog2(NUM_RES) : 1,
  localparam int CNT_W  = $clog2(NUM_RES + 1)
) (
  input logic                      clk,
  input logic                      rst_n,
  input logic                      req_valid,
  input logic                      req_ready,
  input logic                      req_release,
  input logic [CTX_W-1:0]          req_ctx,
  input logic [CNT_W-1:0]          req_cnt,
  input logic                      rsp_valid,
  input logic                      rsp_ok,
  input logic [NUM_RES-1:0]        res_busy,
  input logic [NUM_RES*CTX_W-1:0]  res_owner,
  input logic [NUM_RES*PORT_W-1:0] res_port,
  input logic                      flush_active,
  input logic [NUM_RES-1:0]        flush_mask
);
  // R8: pool state only moves together with a response
  a_r8_busy_moves_with_rsp: assert property (@(posedge clk) disable iff (!rst_n)
    !rsp_valid |-> $stable(res_busy));

  // R4 / R5: a failed request leaves the pool untouched
  a_r4_fail_keeps_pool: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ok) |-> ($stable(res_busy) && $stable(res_owner) && $stable(res_port)));

  // R6: no request is taken while a flush runs
  a_r6_ready_low_in_flush: assert property (@(posedge clk) disable iff (!rst_n)
    flush_active |-> !req_ready);

  // R6: flushed resources are still held
  a_r6_flush_subset: assert property (@(posedge clk) disable iff (!rst_n)
    flush_active |-> ((flush_mask & ~res_busy) == '0));

  // R9: each response has a cause
  a_r9_rsp_has_cause: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> ($past(req_valid && req_ready) || $past(flush_active)));

  // R8: a held resource is never retagged
  for (genvar i = 0; i < NUM_RES; i++) begin : g_own
    a_r8_no_steal: assert property (@(posedge clk) disable iff (!rst_n)
      (res_busy[i] && $past(res_busy[i])) |->
        ($stable(res_owner[i*CTX_W +: CTX_W]) && $stable(res_port[i*PORT_W +: PORT_W])));
  end
endmodule

bind rsa_alloc_unit rsa_alloc_unit_chk #(
  .NUM_RES(NUM_RES), .NUM_CTX(NUM_CTX), .FLUSH_CYCLES(FLUSH_CYCLES)
) u_chk (.*);

// File: tb/rsa_alloc_unit_tb.sv
module rsa_alloc_unit_tb;
  localparam int CLK_PERIOD = 10;
  localparam int NR = 8;
  localparam int NC = 4;
  localparam int FC = 3;
  localparam int CW = 2;
  localparam int PW = 3;
  localparam int NW = 4;

  typedef struct {
    bit               ok;
    logic [NR-1:0]    busy;
    logic [NR*CW-1:0] owner;
    logic [NR*PW-1:0] port;
    int               flen;
    logic [NR-1:0]    mask;
    string            tag;
  } exp_t;

  logic clk = 0, rst_n = 0;
  logic req_valid = 0, req_release = 0;
  logic [CW-1:0] req_ctx = '0;
  logic [NW-1:0] req_cnt = '0;
  logic req_ready, rsp_valid, rsp_ok, flush_active;
  logic [NR-1:0] res_busy, flush_mask;
  logic [NR*CW-1:0] res_owner;
  logic [NR*PW-1:0] res_port;

  int total = 0, bad = 0, frun = 0;
  exp_t q[$];
  bit m_busy[NR];
  int m_own[NR], m_port[NR];

  always #(CLK_PERIOD/2) clk = ~clk;

  rsa_alloc_unit #(.NUM_RES(NR), .NUM_CTX(NC), .FLUSH_CYCLES(FC)) u_dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_release(req_release), .req_ctx(req_ctx), .req_cnt(req_cnt),
    .rsp_valid(rsp_valid), .rsp_ok(rsp_ok), .res_busy(res_busy),
    .res_owner(res_owner), .res_port(res_port),
    .flush_active(flush_active), .flush_mask(flush_mask)
  );

  task automatic chk(bit cond, string req, string what, logic [63:0] act, logic [63:0] exp);
    total++;
    if (!cond) begin
      bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic do_req(bit rel, int ctx, int cnt, string tag);
    exp_t e;
    bit held = 0;
    int nfree = 0, k = 0;
    e.mask = '0;
    e.flen = 0;
    for (int i = 0; i < NR; i++) begin
      if (m_busy[i] && m_own[i] == ctx) begin held = 1; e.mask[i] = 1; end
      if (!m_busy[i]) nfree++;
    end
    if (rel) begin
      e.ok = 1;
      if (held) e.flen = FC;
      for (int i = 0; i < NR; i++)
        if (e.mask[i]) begin m_busy[i] = 0; m_own[i] = 0; m_port[i] = 0; end
    end else begin
      e.ok = !held && cnt > 0 && cnt <= nfree;
      e.mask = '0;
      if (e.ok)
        for (int i = 0; i < NR; i++)
          if (!m_busy[i] && k < cnt) begin
            m_busy[i] = 1; m_own[i] = ctx; m_port[i] = k; k++;
          end
    end
    for (int i = 0; i < NR; i++) begin
      e.busy[i] = m_busy[i];
      e.owner[i*CW +: CW] = CW'(m_own[i]);
      e.port[i*PW +: PW] = PW'(m_port[i]);
    end
    e.tag = tag;
    q.push_back(e);
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    req_valid = 1; req_release = rel; req_ctx = CW'(ctx); req_cnt = NW'(cnt);
    @(negedge clk);
    req_valid = 0;
  endtask

  // monitor / scoreboard
  always @(negedge clk) begin
    if (rst_n) begin
      if (flush_active) begin
        frun++;
        chk(!req_ready, "R6", "ready during flush", req_ready, 0);
        if (q.size() > 0) chk(flush_mask == q[0].mask, "R6", "flush_mask", flush_mask, q[0].mask);
      end
      if (rsp_valid) begin
        if (q.size() == 0) begin
          chk(0, "R9", "unexpected rsp", 1, 0);
        end else begin
          exp_t e;
          e = q.pop_front();
          chk(rsp_ok == e.ok, e.tag, "rsp_ok", rsp_ok, e.ok);
          chk(res_busy == e.busy, e.tag, "busy", res_busy, e.busy);
          chk(res_owner == e.owner, e.tag, "owner (R3 layout)", res_owner, e.owner);
          chk(res_port == e.port, "R3", "port", res_port, e.port);
          chk(frun == e.flen, e.flen > 0 ? "R6" : "R7", "flush length", frun, e.flen);
        end
        frun = 0;
      end
    end
  end

  initial begin
    for (int i = 0; i < NR; i++) begin m_busy[i] = 0; m_own[i] = 0; m_port[i] = 0; end
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    chk(res_busy == '0, "R1", "busy", res_busy, 0);
    chk(res_owner == '0 && res_port == '0, "R1", "owner/port", {res_owner, res_port}, 0);
    chk(req_ready && !rsp_valid && !flush_active, "R1", "ctl", {req_ready, rsp_valid, flush_active}, 3'b100);

    do_req(0, 0, 3, "R2");
    do_req(0, 1, 2, "R2");
    do_req(0, 0, 1, "R5");   // already holds
    do_req(0, 2, 0, "R5");   // count zero
    do_req(0, 2, 4, "R4");   // only 3 free
    do_req(0, 2, 3, "R2");   // fills pool
    do_req(0, 3, 1, "R4");   // pool full
    do_req(1, 0, 0, "R6");
    do_req(1, 3, 0, "R7");   // holds nothing
    do_req(0, 3, 2, "R2");
    do_req(0, 0, 1, "R2");   // last free below ctx1
    do_req(1, 1, 0, "R8");   // frees 3,4 only
    do_req(0, 1, 2, "R3");
    do_req(1, 3, 0, "R6");
    do_req(1, 2, 0, "R8");
    do_req(0, 2, 4, "R3");   // scattered free slots
    do_req(1, 0, 0, "R6");
    do_req(1, 1, 0, "R6");
    do_req(1, 2, 0, "R6");
    do_req(0, 1, 9, "R4");   // more than pool
    do_req(0, 1, 8, "R2");   // whole pool
    do_req(1, 1, 0, "R6");
    repeat (FC + 4) @(negedge clk);
    chk(q.size() == 0, "R9", "pending responses", q.size(), 0);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    total++; bad++;
    $display("FAIL R9 watchdog actual=timeout expected=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule